// File: doc/BRIEF.md
# Glitchless Clock Source Switch

This block picks one of two running clocks and passes it to a single clock output without ever producing a shortened high or low phase. One input is a fixed reference clock. The other is an auxiliary path: a plain combinational pre-selector that takes one of six clock sources. The pre-selector is cheap, but it may glitch when its select changes. For that reason it should only be reconfigured while the auxiliary path is not driving the output.

Each of the two main inputs has its own gating branch. A request for a branch passes through a short synchronizer clocked by that branch's own clock. The branch's enable changes only on that clock's falling edge. A branch may turn on only while the other branch's enable is low, so the outgoing clock is always shut off before the incoming one starts. A two-bit status word reports which branch is currently gating its clock onto the output. The main select may be changed at any time while the clocks run. Clock generation and register decoding sit outside this block.

Top module: `glitchless_clk_sw`

## Requirements
- R1: After reset, `active_o` reads 2'b01 and `clk_o` follows `ref_clk_i`.
- R2: With `src_sel_i` = 0 and the handover finished, `active_o` reads 2'b01 (bit 0 = reference branch) and `clk_o` has the period of `ref_clk_i`.
- R3: With `src_sel_i` = 1 and a valid auxiliary encoding, `active_o` reads 2'b10 (bit 1 = auxiliary branch) and `clk_o` has the period of the chosen auxiliary source.
- R4: Auxiliary encodings 0 to 5 pick `aux_clk_i[k]` for encoding k. Changing the auxiliary select while the reference branch is active leaves `clk_o` at the reference period.
- R5: Auxiliary encodings 6 and 7 drive the auxiliary path constant low. Selecting the auxiliary path with such an encoding leaves `active_o` at 2'b00 and `clk_o` low. Selecting the reference again brings `active_o` back to 2'b01.
- R6: `active_o` never has more than one bit set.
- R7: While `active_o` reads 2'b00, `clk_o` is low.
- R8: No high or low phase on `clk_o` is shorter than the shorter half-period of the sources in use. This holds even when the select is pulsed briefly or reversed in the middle of a handover.
- R9: A branch turns on only while the other branch is off, so every change of main source passes through `active_o` = 2'b00.
- R10: A handover completes within four periods of the outgoing clock plus four periods of the incoming clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock, main source 0 |
| aux_clk_i | input | 6 | Auxiliary clock sources, index = auxiliary encoding |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 1 | Main select: 0 reference, 1 auxiliary path |
| aux_sel_i | input | 3 | Auxiliary pre-selector encoding (6 and 7 reserved) |
| clk_o | output | 1 | Switched clock |
| active_o | output | 2 | One-hot-or-zero branch status, bit 0 reference, bit 1 auxiliary |

## Verification
The bench measures every phase on `clk_o` and compares it with the shorter half-period of the sources in play. A design that gated on the rising edge, or that let both branches overlap, would show up as a runt phase. Select pulses shorter than the synchronizer latency and reversals made at the moment both branches are off target the cross-coupled interlock. A version lacking the interlock would set both status bits or merge the two clocks. Reserved auxiliary encodings check that the switch parks low with zero status and still recovers to the reference; a design that waited for the other branch's status would stay stuck. Each handover is timed against its bound, and the output period is measured once the handover settles.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  localparam int unsigned MAIN_SRC_COUNT = 2;
  localparam int unsigned MAIN_SEL_BITS  = 1;
  localparam int unsigned AUX_SRC_COUNT  = 6;
  localparam int unsigned AUX_SEL_BITS   = 3;
  localparam int unsigned SYNC_DEPTH     = 2;

  typedef logic [MAIN_SRC_COUNT-1:0] src_vec_t;
endpackage

// File: rtl/clk_sw_aux_mux.sv
module clk_sw_aux_mux #(
  parameter int unsigned NUM_AUX   = 6,
  parameter int unsigned AUX_SEL_W = 3
) (
  input  logic [NUM_AUX-1:0]   src_clk_i,
  input  logic [AUX_SEL_W-1:0] sel_i,
  output logic                 clk_o
);
  // plain mux, unused encodings park low
  always_comb begin
    clk_o = 1'b0;
    for (int k = 0; k < NUM_AUX; k++) begin
      if (sel_i == AUX_SEL_W'(k)) clk_o = src_clk_i[k];
    end
  end
endmodule

// File: rtl/clk_sw_branch.sv
module clk_sw_branch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RESET_ON    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic block_i,
  output logic en_o,
  output logic gclk_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {SYNC_STAGES{RESET_ON}};
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], req_i};
  end

  // falling-edge update keeps the current high phase whole
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RESET_ON;
    else         en_q <= sync_q[SYNC_STAGES-1] & ~block_i;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/glitchless_clk_sw.sv
module glitchless_clk_sw
  import clk_sw_pkg::*;
#(
  parameter int unsigned NUM_AUX     = AUX_SRC_COUNT,
  parameter int unsigned AUX_SEL_W   = AUX_SEL_BITS,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic                      ref_clk_i,
  input  logic [NUM_AUX-1:0]        aux_clk_i,
  input  logic                      rst_ni,
  input  logic [MAIN_SEL_BITS-1:0]  src_sel_i,
  input  logic [AUX_SEL_W-1:0]      aux_sel_i,
  output logic                      clk_o,
  output logic [MAIN_SRC_COUNT-1:0] active_o
);
  logic     aux_mux_clk;
  src_vec_t src_clk_w;
  src_vec_t en_w;
  src_vec_t gclk_w;
  src_vec_t req_w;

  clk_sw_aux_mux #(
    .NUM_AUX  (NUM_AUX),
    .AUX_SEL_W(AUX_SEL_W)
  ) u_aux_mux (
    .src_clk_i(aux_clk_i),
    .sel_i    (aux_sel_i),
    .clk_o    (aux_mux_clk)
  );

  assign src_clk_w = {aux_mux_clk, ref_clk_i};

  for (genvar i = 0; i < MAIN_SRC_COUNT; i++) begin : g_branch
    logic others_on;
    assign others_on = |(en_w & ~(src_vec_t'(1) << i));
    assign req_w[i]  = (src_sel_i == MAIN_SEL_BITS'(i)) && !others_on;

    clk_sw_branch #(
      .SYNC_STAGES(SYNC_STAGES),
      .RESET_ON   (i == 0)
    ) u_branch (
      .clk_i  (src_clk_w[i]),
      .rst_ni (rst_ni),
      .req_i  (req_w[i]),
      .block_i(others_on),
      .en_o   (en_w[i]),
      .gclk_o (gclk_w[i])
    );
  end

  assign clk_o    = |gclk_w;
  assign active_o = en_w;
endmodule

// File: rtl/clk_sw_chk.sv
module clk_sw_chk (
  input logic       ref_clk_i,
  input logic       aux_clk_i,
  input logic       rst_ni,
  input logic [1:0] active_i,
  input logic       clk_i
);
  // R6
  onehot_status_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $onehot0(active_i));

  // R7
  always_comb begin
    if (rst_ni === 1'b1 && active_i == 2'b00) begin
      idle_low_chk: assert (clk_i == 1'b0);
    end
  end

  // R8
  always @(active_i[0]) begin
    if (rst_ni === 1'b1) begin
      ref_edge_chk: assert (ref_clk_i == 1'b0);
    end
  end

  // R8
  always @(active_i[1]) begin
    if (rst_ni === 1'b1) begin
      aux_edge_chk: assert (aux_clk_i == 1'b0);
    end
  end

  // R9
  always @(posedge active_i[0]) begin
    if (rst_ni === 1'b1) begin
      ref_after_aux_chk: assert (active_i[1] == 1'b0);
    end
  end

  // R9
  always @(posedge active_i[1]) begin
    if (rst_ni === 1'b1) begin
      aux_after_ref_chk: assert (active_i[0] == 1'b0);
    end
  end
endmodule

bind glitchless_clk_sw clk_sw_chk u_chk (
  .ref_clk_i(ref_clk_i),
  .aux_clk_i(aux_mux_clk),
  .rst_ni   (rst_ni),
  .active_i (active_o),
  .clk_i    (clk_o)
);

// File: tb/glitchless_clk_sw_tb.sv
`timescale 1ns/1ps
module glitchless_clk_sw_tb;
  typedef struct {
    logic [1:0] status;
    real        period;
    real        bound;
    bit         gap;
    string      rq;
  } item_t;

  logic       ref_clk = 1'b0;
  logic [5:0] aux_clk = '0;
  logic       rst_n   = 1'b0;
  logic       src_sel = 1'b0;
  logic [2:0] aux_sel = '0;
  logic       clk_out;
  logic [1:0] active;

  real   aux_half [6] = '{7.0, 13.0, 17.0, 9.0, 23.0, 15.0};
  item_t sb_q [$];
  int    checks = 0, errors = 0, runt_errs = 0;
  bit    cur_sel = 1'b0;
  int    cur_aux = 0;
  real   cur_period = 20.0;
  bit    mon_busy = 1'b0;
  bit    finished = 1'b0;
  real   last_edge = -1.0;

  glitchless_clk_sw u_dut (
    .ref_clk_i(ref_clk),
    .aux_clk_i(aux_clk),
    .rst_ni   (rst_n),
    .src_sel_i(src_sel),
    .aux_sel_i(aux_sel),
    .clk_o    (clk_out),
    .active_o (active)
  );

  // 50 MHz reference; aux edges offset off the integer grid
  always #10 ref_clk = ~ref_clk;
  initial begin #0.2; forever #7  aux_clk[0] = ~aux_clk[0]; end
  initial begin #0.3; forever #13 aux_clk[1] = ~aux_clk[1]; end
  initial begin #0.4; forever #17 aux_clk[2] = ~aux_clk[2]; end
  initial begin #0.6; forever #9  aux_clk[3] = ~aux_clk[3]; end
  initial begin #0.7; forever #23 aux_clk[4] = ~aux_clk[4]; end
  initial begin #0.8; forever #15 aux_clk[5] = ~aux_clk[5]; end

  function automatic real period_of(bit s, int a);
    if (!s) return 20.0;
    if (a < 6) return 2.0 * aux_half[a];
    return 0.0;
  endfunction

  task automatic chk(bit ok, string rq, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  task automatic align();
    real f;
    f = $realtime - $floor($realtime);
    if (f < 0.5) #(0.5 - f);
    else         #(1.5 - f);
  endtask

  task automatic settle();
    #1;
    while (mon_busy || sb_q.size() != 0) #1;
  endtask

  // driver: drive selects, push expected result
  task automatic apply(bit s, int a, string rq);
    item_t it;
    real   np;
    np        = period_of(s, a);
    it.status = !s ? 2'b01 : (a < 6 ? 2'b10 : 2'b00);
    it.period = np;
    it.bound  = 4.0 * (cur_period + np) + 2.0;
    it.gap    = (s != cur_sel);
    it.rq     = rq;
    src_sel   = s;
    aux_sel   = 3'(a);
    cur_aux   = a;
    cur_sel   = s;
    cur_period = np;
    sb_q.push_back(it);
    settle();
  endtask

  task automatic pulse_sel();
    src_sel = ~cur_sel;
    #15;
    src_sel = cur_sel;
    #400;
    apply(cur_sel, cur_aux, "R8");
  endtask

  task automatic abort_mid();
    int n = 0;
    src_sel = ~cur_sel;
    while (active != 2'b00 && n < 500) begin #1; n++; end
    src_sel = cur_sel;
    #400;
    apply(cur_sel, cur_aux, "R8");
  endtask

  // monitor: pop expected items and compare against the outputs
  initial begin
    item_t it;
    real   t0, t1, d;
    bit    done, saw_gap, gap_bad, both;
    forever begin
      align();
      while (sb_q.size() == 0) #1;
      mon_busy = 1'b1;
      it = sb_q.pop_front();
      t0 = $realtime; done = 0; saw_gap = 0; gap_bad = 0; both = 0;
      while (!done && ($realtime - t0) <= it.bound) begin
        if (active == 2'b00) begin
          saw_gap = 1;
          if (clk_out !== 1'b0) gap_bad = 1;
        end
        if (active == 2'b11) both = 1;
        if (active === it.status) done = 1;
        else #1;
      end
      chk(done, "R10", $sformatf("handover time actual >%0.1f ns expected <=%0.1f ns", $realtime - t0, it.bound));
      chk(active === it.status, it.rq, $sformatf("status actual %b expected %b", active, it.status));
      chk(!both, "R6", $sformatf("status actual 2'b11 seen expected at most one bit"));
      if (it.gap) begin
        chk(saw_gap, "R9", $sformatf("zero status during handover actual %0d expected 1", saw_gap));
        chk(!gap_bad, "R7", $sformatf("output while status zero actual high expected low"));
      end
      if (done && it.period > 0.0) begin
        @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); t1 = $realtime;
        d = (t1 - t0) - it.period;
        if (d < 0.0) d = -d;
        chk(d < 0.05, it.rq, $sformatf("output period actual %0.2f ns expected %0.2f ns", t1 - t0, it.period));
      end else if (done) begin
        align();
        gap_bad = 0;
        repeat (200) begin
          if (clk_out !== 1'b0 || active !== 2'b00) gap_bad = 1;
          #1;
        end
        chk(!gap_bad, "R5", $sformatf("parked output actual active=%b clk=%b expected 00/0", active, clk_out));
      end
      mon_busy = 1'b0;
    end
  end

  // runt detector on every output phase
  always @(clk_out) begin
    if (rst_n === 1'b1) begin
      if (last_edge >= 0.0) begin
        real dt, lim;
        dt  = $realtime - last_edge;
        lim = 10.0;
        if (cur_aux < 6 && aux_half[cur_aux] < lim) lim = aux_half[cur_aux];
        if (dt < lim - 0.01) begin
          runt_errs++;
          $display("FAIL R8: phase actual %0.2f ns expected >= %0.2f ns at %0.2f", dt, lim, $realtime);
        end
      end
      last_edge = $realtime;
    end
  end

  initial begin
    rst_n = 1'b0;
    #55;
    chk(active === 2'b01, "R1", $sformatf("reset status actual %b expected 01", active));
    chk(clk_out === ref_clk, "R1", $sformatf("reset output actual %b expected %b", clk_out, ref_clk));
    @(negedge ref_clk);
    #3.1;
    rst_n = 1'b1;
    apply(1'b0, 0, "R1");
    apply(1'b1, 0, "R3");
    apply(1'b0, 0, "R2");
    for (int k = 1; k < 6; k++) begin
      apply(1'b0, k, "R4");
      apply(1'b1, k, "R4");
      apply(1'b0, k, "R2");
    end
    apply(1'b0, 6, "R5");
    apply(1'b1, 6, "R5");
    apply(1'b0, 6, "R5");
    apply(1'b0, 7, "R5");
    apply(1'b1, 7, "R5");
    apply(1'b0, 7, "R5");
    apply(1'b0, 1, "R4");
    pulse_sel();
    abort_mid();
    apply(1'b1, 1, "R3");
    pulse_sel();
    abort_mid();
    apply(1'b0, 1, "R2");
    chk(runt_errs == 0, "R8", $sformatf("runt phases actual %0d expected 0", runt_errs));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: completion actual none expected before timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule